// File: doc/BRIEF.md
# Half-Duplex Collision Backoff Controller

This block decides what a half-duplex transmitter does after a collision. While a frame is on the wire it counts the collisions the frame has suffered. On each new collision it either gives up on the frame or schedules a retry after a random delay. The delay is a whole number r of slot times, where r is drawn from a free-running pseudo-random sequence and kept below 2^k. The exponent k is the collision count n, capped at a ceiling picked by a 2-bit limit code.

A slot time is counted in bit times. The caller supplies a strobe, `bit_tick`, that pulses once per bit time at the current line rate. The slot is longer in gigabit mode than at the lower rates. A retry-disable input turns the block into a single-attempt controller. An attempt limit ends a frame that keeps colliding. In both cases the abort is reported as an excessive-collision outcome, and that outcome is held on the status output until the next frame starts. Collisions are ignored while the link is in full-duplex mode.

The control is a four-state machine. ST_IDLE waits for a frame and goes to ST_XMIT on `frame_start`. ST_XMIT returns to ST_IDLE on `frame_done`. On a collision, ST_XMIT goes to ST_ABORT if this was the last allowed attempt, and to ST_WAIT otherwise. ST_WAIT returns to ST_XMIT with a one-cycle `retry_go` once the drawn number of slots has elapsed. ST_ABORT lasts one cycle, raising `abort_pulse`, and then falls back to ST_IDLE.

Top module: `hd_backoff_ctrl`

## Requirements
- R1: After reset, `status` is 2'b00 (idle, no excessive-collision outcome) and neither `retry_go` nor `abort_pulse` is high.
- R2: In idle, `frame_start` moves `status` to 2'b01 (transmitting) on the next cycle. In transmitting, `frame_done` with no collision moves `status` back to 2'b00.
- R3: A collision that schedules a retry draws r with 0 ≤ r < 2^k. Here k = min(n, cap), n is the number of collisions of the current frame including this one, and cap is 10, 8, 4 or 1 for `limit_code` 0, 1, 2 or 3.
- R4: After such a collision, `status` reads 2'b10 (waiting). `retry_go` rises once exactly r × S `bit_tick` pulses have been counted after the collision cycle. S is SLOT_GIG when `gig_mode` is 1 and SLOT_SLOW otherwise (defaults 4096 and 512). `retry_go` lasts one cycle, after which `status` is 2'b01 again.
- R5: With `single_try` high, the first collision gives `abort_pulse` on the next cycle with `status` 2'b11, and no retry follows.
- R6: With `single_try` low, collisions 1 to MAX_ATTEMPTS−1 (default 16) each lead to a retry, and collision number MAX_ATTEMPTS gives `abort_pulse` with `status` 2'b11.
- R7: While `full_duplex` is high, `collision` has no effect: `status` stays 2'b01 and neither `abort_pulse` nor `retry_go` rises.
- R8: After an abort, `abort_pulse` lasts one cycle. `status` then holds 2'b11 in idle until the next `frame_start`, which moves it to 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| full_duplex | input | 1 | 1 = full-duplex link; collisions are ignored |
| gig_mode | input | 1 | 1 = gigabit slot length, 0 = lower-rate slot length |
| bit_tick | input | 1 | One pulse per bit time at the current rate |
| limit_code | input | 2 | Backoff exponent ceiling select: 0→10, 1→8, 2→4, 3→1 |
| single_try | input | 1 | 1 = abort on the first collision |
| frame_start | input | 1 | Start of a new frame (taken in idle) |
| frame_done | input | 1 | Current frame sent without collision |
| collision | input | 1 | Collision seen during the current attempt |
| retry_go | output | 1 | One-cycle pulse: backoff over, retransmit now |
| abort_pulse | output | 1 | One-cycle pulse: frame abandoned |
| status | output | 2 | 00 idle, 01 transmitting, 10 waiting, 11 excessive-collision abort |

## Verification
`status` follows `frame_start`, `frame_done` and a collision one cycle after the edge that samples them. `abort_pulse` appears in that same cycle. `retry_go` appears once r × S ticks have been sampled, counting from the edge after the collision. The bench drives every input on the falling edge and samples on the following falling edge. While a backoff runs, it counts the ticks it has itself presented to the design, edge by edge. When `retry_go` is seen, that count must be a whole multiple of S, and the quotient must fall below 2^k as the bench computes it from n and the limit code. `status` must read 2'b01 exactly one cycle later. Abort, hold and full-duplex outcomes are sampled at the first and second cycles after the collision edge.

// File: rtl/bko_pkg.sv
package bko_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XMIT,
        ST_WAIT,
        ST_ABORT
    } bko_state_e;

    localparam logic [1:0] STAT_IDLE   = 2'b00;
    localparam logic [1:0] STAT_XMIT   = 2'b01;
    localparam logic [1:0] STAT_WAIT   = 2'b10;
    localparam logic [1:0] STAT_EXCESS = 2'b11;

    // Exponent ceiling selected by the 2-bit limit code.
    function automatic logic [31:0] exp_cap(input logic [1:0] code);
        logic [31:0] cap;
        unique case (code)
            2'd0:    cap = 32'd10;
            2'd1:    cap = 32'd8;
            2'd2:    cap = 32'd4;
            default: cap = 32'd1;
        endcase
        return cap;
    endfunction

endpackage

// File: rtl/bko_lfsr.sv
module bko_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    logic [W-1:0] lfsr_q;

    // Galois form, shifting right; never reaches zero from a nonzero seed.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            lfsr_q <= W'(1);
        else if (lfsr_q[0])
            lfsr_q <= (lfsr_q >> 1) ^ TAPS;
        else
            lfsr_q <= lfsr_q >> 1;
    end

    assign value = lfsr_q;
endmodule

// File: rtl/bko_draw.sv
module bko_draw #(
    parameter int CNT_W = 5,
    parameter int R_W   = 10,
    parameter int KW    = 4
) (
    input  logic [CNT_W-1:0] attempt,
    input  logic [1:0]       limit_code,
    input  logic [R_W-1:0]   rnd,
    output logic [R_W-1:0]   draw
);
    logic [31:0]  cap;
    logic [KW-1:0] k;
    logic [R_W:0]  span;

    always_comb begin
        cap = bko_pkg::exp_cap(limit_code);
        if (32'(attempt) < cap)
            k = KW'(attempt);
        else
            k = KW'(cap);
        // span = 2^k - 1, at most R_W ones
        span = ((R_W+1)'(1) << k) - (R_W+1)'(1);
        draw = rnd & span[R_W-1:0];
    end
endmodule

// File: rtl/bko_slot_timer.sv
module bko_slot_timer #(
    parameter int SLOT_GIG  = 4096,
    parameter int SLOT_SLOW = 512,
    parameter int R_W       = 10
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [R_W-1:0] load_slots,
    input  logic           gig_mode,
    input  logic           bit_tick,
    output logic           expired
);
    localparam int BW = $clog2(SLOT_GIG);
    localparam logic [BW-1:0] LAST_GIG  = BW'(SLOT_GIG - 1);
    localparam logic [BW-1:0] LAST_SLOW = BW'(SLOT_SLOW - 1);

    logic [R_W-1:0] slots_q;
    logic [BW-1:0]  bits_q;
    logic [BW-1:0]  last_bit;

    assign last_bit = gig_mode ? LAST_GIG : LAST_SLOW;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slots_q <= '0;
            bits_q  <= '0;
        end else if (load) begin
            slots_q <= load_slots;
            bits_q  <= '0;
        end else if (bit_tick && slots_q != '0) begin
            if (bits_q == last_bit) begin
                bits_q  <= '0;
                slots_q <= slots_q - R_W'(1);
            end else begin
                bits_q  <= bits_q + BW'(1);
            end
        end
    end

    assign expired = (slots_q == '0);
endmodule

// File: rtl/hd_backoff_ctrl.sv
module hd_backoff_ctrl #(
    parameter int SLOT_GIG     = 4096,
    parameter int SLOT_SLOW    = 512,
    parameter int MAX_ATTEMPTS = 16,
    parameter int RAND_W       = 16,
    parameter int EXP_MAX      = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       full_duplex,
    input  logic       gig_mode,
    input  logic       bit_tick,
    input  logic [1:0] limit_code,
    input  logic       single_try,
    input  logic       frame_start,
    input  logic       frame_done,
    input  logic       collision,
    output logic       retry_go,
    output logic       abort_pulse,
    output logic [1:0] status
);
    import bko_pkg::*;

    localparam int CNT_W = $clog2(MAX_ATTEMPTS + 1);
    localparam int R_W   = EXP_MAX;
    localparam int KW    = $clog2(EXP_MAX + 1);

    bko_state_e     state_q, state_d;
    logic [CNT_W-1:0] col_q;
    logic [CNT_W-1:0] col_next;
    logic           excess_q;
    logic           hit;
    logic           last_try;
    logic           load_wait;
    logic [RAND_W-1:0] rnd;
    logic [R_W-1:0] draw;
    logic           slots_over;

    assign col_next  = col_q + CNT_W'(1);
    assign hit       = collision && !full_duplex;
    assign last_try  = single_try || (32'(col_next) >= 32'(MAX_ATTEMPTS));
    assign load_wait = (state_q == ST_XMIT) && hit && !last_try;

    bko_lfsr #(.W(RAND_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .value (rnd)
    );

    bko_draw #(.CNT_W(CNT_W), .R_W(R_W), .KW(KW)) u_draw (
        .attempt    (col_next),
        .limit_code (limit_code),
        .rnd        (rnd[R_W-1:0]),
        .draw       (draw)
    );

    bko_slot_timer #(.SLOT_GIG(SLOT_GIG), .SLOT_SLOW(SLOT_SLOW), .R_W(R_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load_wait),
        .load_slots (draw),
        .gig_mode   (gig_mode),
        .bit_tick   (bit_tick),
        .expired    (slots_over)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (frame_start) state_d = ST_XMIT;
            ST_XMIT: begin
                if (hit)             state_d = last_try ? ST_ABORT : ST_WAIT;
                else if (frame_done) state_d = ST_IDLE;
            end
            ST_WAIT:  if (slots_over) state_d = ST_XMIT;
            ST_ABORT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register with per-frame collision count and sticky outcome
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            col_q    <= '0;
            excess_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && frame_start) begin
                col_q    <= '0;
                excess_q <= 1'b0;
            end else if (state_q == ST_XMIT && hit) begin
                col_q <= col_next;
                if (last_try) excess_q <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        retry_go    = 1'b0;
        abort_pulse = 1'b0;
        status      = STAT_IDLE;
        unique case (state_q)
            ST_IDLE:  status = excess_q ? STAT_EXCESS : STAT_IDLE;
            ST_XMIT:  status = STAT_XMIT;
            ST_WAIT: begin
                status   = STAT_WAIT;
                retry_go = slots_over;
            end
            ST_ABORT: begin
                status      = STAT_EXCESS;
                abort_pulse = 1'b1;
            end
            default:  status = STAT_IDLE;
        endcase
    end
endmodule

// File: rtl/bko_checker.sv
module bko_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       full_duplex,
    input logic       single_try,
    input logic       frame_start,
    input logic       frame_done,
    input logic       collision,
    input logic       retry_go,
    input logic       abort_pulse,
    input logic [1:0] status
);
    assert_start_xmit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((status == 2'b00 || status == 2'b11) && !abort_pulse && frame_start) |=> status == 2'b01);

    assert_wait_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b10 && !retry_go) |=> status == 2'b10);

    assert_retry_resumes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        retry_go |=> (status == 2'b01 && !retry_go));

    assert_single_try_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b01 && collision && !full_duplex && single_try) |=> abort_pulse);

    assert_fd_ignores_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b01 && full_duplex && !frame_done) |=> status == 2'b01);

    assert_abort_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> (status == 2'b11 && !abort_pulse));

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({retry_go, abort_pulse}));
endmodule

bind hd_backoff_ctrl bko_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .full_duplex (full_duplex),
    .single_try  (single_try),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .collision   (collision),
    .retry_go    (retry_go),
    .abort_pulse (abort_pulse),
    .status      (status)
);

// File: tb/hd_backoff_ctrl_tb.sv
`timescale 1ns/1ps
module hd_backoff_ctrl_tb;
    localparam int SG = 64;
    localparam int SS = 8;
    localparam int MAXA = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic full_duplex = 1'b0, gig_mode = 1'b0, bit_tick = 1'b1;
    logic [1:0] limit_code = 2'd0;
    logic single_try = 1'b0, frame_start = 1'b0, frame_done = 1'b0, collision = 1'b0;
    logic retry_go, abort_pulse;
    logic [1:0] status;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit seen_r0 = 0, seen_r1 = 0;

    always #2.5 clk = ~clk;

    hd_backoff_ctrl #(.SLOT_GIG(SG), .SLOT_SLOW(SS), .MAX_ATTEMPTS(MAXA)) u_dut (
        .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .gig_mode(gig_mode),
        .bit_tick(bit_tick), .limit_code(limit_code), .single_try(single_try),
        .frame_start(frame_start), .frame_done(frame_done), .collision(collision),
        .retry_go(retry_go), .abort_pulse(abort_pulse), .status(status)
    );

    function automatic int cap_of(input int code);
        case (code)
            0: return 10;
            1: return 8;
            2: return 4;
            default: return 1;
        endcase
    endfunction

    function automatic int k_of(input int n, input int code);
        return (n < cap_of(code)) ? n : cap_of(code);
    endfunction

    function automatic int slot_of(input bit gig);
        return gig ? SG : SS;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
            summary();
            $finish;
        end
    end

    task automatic start_frame();
        @(negedge clk) frame_start = 1'b1;
        @(negedge clk) frame_start = 1'b0;
        chk(status == 2'b01, "R2 start", status, 1);
    endtask

    task automatic end_frame();
        @(negedge clk) frame_done = 1'b1;
        @(negedge clk) frame_done = 1'b0;
        chk(status == 2'b00, "R2 done", status, 0);
    endtask

    // Collision n of the current frame, expecting a retry; measures r.
    task automatic collide_retry(input int n, input int code, input bit gig);
        int ticks;
        int r;
        int guard;
        ticks = 0;
        guard = 0;
        @(negedge clk) collision = 1'b1;
        @(negedge clk) collision = 1'b0;
        if (!retry_go)
            chk(status == 2'b10, "R4 waiting", status, 2);
        while (!retry_go && guard < 150000) begin
            bit_tick = ($urandom_range(0, 3) != 0);
            @(negedge clk);
            if (bit_tick) ticks++;
            guard++;
        end
        chk(ticks % slot_of(gig) == 0, "R4 whole slots", ticks % slot_of(gig), 0);
        r = ticks / slot_of(gig);
        chk(r < (1 << k_of(n, code)), "R3 range", r, (1 << k_of(n, code)) - 1);
        if (code == 3) begin
            if (r == 0) seen_r0 = 1;
            if (r == 1) seen_r1 = 1;
        end
        bit_tick = 1'b1;
        @(negedge clk);
        chk(status == 2'b01 && !retry_go, "R4 resume", status, 1);
    endtask

    initial begin
        void'($urandom(32'd5171));
        repeat (3) @(negedge clk);
        chk(status == 2'b00, "R1 status", status, 0);
        chk(!retry_go && !abort_pulse, "R1 pulses", {retry_go, abort_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(status == 2'b00, "R1 after release", status, 0);

        // R2 plain frame
        start_frame();
        end_frame();

        // R3/R4 random frames
        for (int t = 0; t < 30; t++) begin
            int code;
            int ncol;
            bit gig;
            code = $urandom_range(0, 3);
            gig = (code >= 2) ? bit'($urandom_range(0, 1)) : 1'b0;
            ncol = $urandom_range(1, 6);
            limit_code = 2'(code);
            gig_mode = gig;
            start_frame();
            for (int c = 1; c <= ncol; c++) collide_retry(c, code, gig);
            end_frame();
        end

        // R3 saturation of the exponent at 10 and 8
        limit_code = 2'd0; gig_mode = 1'b0;
        start_frame();
        for (int c = 1; c <= 12; c++) collide_retry(c, 0, 1'b0);
        end_frame();
        limit_code = 2'd1;
        start_frame();
        for (int c = 1; c <= 10; c++) collide_retry(c, 1, 1'b0);
        end_frame();

        // R6 attempt limit, R8 sticky outcome
        limit_code = 2'd3; gig_mode = 1'b1;
        start_frame();
        for (int c = 1; c < MAXA; c++) collide_retry(c, 3, 1'b1);
        @(negedge clk) collision = 1'b1;
        @(negedge clk) collision = 1'b0;
        chk(abort_pulse == 1'b1, "R6 abort", abort_pulse, 1);
        chk(status == 2'b11, "R6 status", status, 3);
        @(negedge clk);
        chk(!abort_pulse && status == 2'b11, "R8 hold", status, 3);
        repeat (4) @(negedge clk);
        chk(status == 2'b11 && !retry_go, "R8 hold idle", status, 3);
        start_frame();
        end_frame();
        chk(seen_r0 && seen_r1, "R3 both draws for cap 1", {seen_r0, seen_r1}, 3);

        // R5 single attempt
        single_try = 1'b1; limit_code = 2'd0;
        start_frame();
        @(negedge clk) collision = 1'b1;
        @(negedge clk) collision = 1'b0;
        chk(abort_pulse == 1'b1 && status == 2'b11, "R5 abort", status, 3);
        @(negedge clk);
        chk(!abort_pulse && !retry_go && status == 2'b11, "R5 no retry", status, 3);
        single_try = 1'b0;

        // R7 full duplex
        start_frame();
        full_duplex = 1'b1;
        @(negedge clk) collision = 1'b1;
        @(negedge clk) collision = 1'b0;
        for (int i = 0; i < 3; i++) begin
            chk(status == 2'b01 && !abort_pulse && !retry_go, "R7 ignored", status, 1);
            @(negedge clk);
        end
        full_duplex = 1'b0;
        end_frame();

        summary();
        $finish;
    end
endmodule